// File: doc/BRIEF.md
# Split-Read 64-bit Cycle Counter

This block keeps a free-running 64-bit count of system clock cycles and lets a 32-bit core read it with one read operation issued twice in a row. Software sees no write path. A read made while no read window is open returns the low word. That same read captures the high word into a holding register and opens a window that lasts exactly one instruction cycle. A read made inside that window returns the held high word and closes the window. The two halves therefore always come from the same instant, even when the low word wraps between the two reads.

The open window is also driven out as an interrupt hold-off request, so the core's interrupt logic cannot split the pair. A per-core reset closes the window at any time, so a core that is restarted mid-pair always begins again with a low-word read. Each read also sets two flag outputs from the top two bits of the returned word. The result register, the flags and the window are all registered, so every read shows its result one clock after the strobe.

Top module: `sysctr_split_read`

## Requirements
- R1: On rst_ni low the counter loads CNT_RESET (default zero), rd_data_o, both flags and irq_hold_o go to 0, and afterwards the counter rises by exactly one on every clock; no input changes its value.
- R2: A read strobe while the window is closed puts counter bits [31:0], as they were at that clock edge, on rd_data_o one clock later, and opens the window.
- R3: A read strobe while the window is open puts the counter bits [63:32] that were captured at the opening low read on rd_data_o one clock later, and closes the window.
- R4: The window stays open for exactly one clock. If no read comes in that clock the window closes, and the next read returns the low word.
- R5: A pair read whose low word is 0xFFFFFFFF returns the high word from before the low word wrapped, not the incremented one.
- R6: A run of back-to-back read strobes returns low, high, low, high and so on, starting with low.
- R7: irq_hold_o is 1 during exactly the clock in which the window is open, and 0 otherwise.
- R8: core_rst_i closes the window by the next clock. A read strobe in the same clock is ignored, so rd_data_o and the flags hold, and the next read returns the low word.
- R9: flag_c_o equals bit 31 and flag_z_o equals bit 30 of the word most recently returned, and both change in the same clock as rd_data_o.
- R10: In a clock with no read strobe, rd_data_o, flag_c_o and flag_z_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; the counter advances on each rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_strobe_i | input | 1 | One-cycle pulse per counter read instruction |
| core_rst_i | input | 1 | Per-core reset; closes the read window |
| rd_data_o | output | 32 | Word returned by the latest read |
| flag_c_o | output | 1 | Carry flag: bit 31 of the returned word |
| flag_z_o | output | 1 | Zero flag: bit 30 of the returned word |
| irq_hold_o | output | 1 | Interrupt hold-off request while the window is open |

## Verification
The bench starts the counter just below a low-word wrap and reads a pair whose low half is 0xFFFFFFFF. A design that fed the live high word to the second read would return a high half that is one too large. Bursts of back-to-back strobes catch a window that does not close on the high read, which would show up as two high reads in a row. A lone low read followed by an idle cycle catches a window that stays open for longer than one instruction. A core reset placed inside an open window, with and without a strobe in the same cycle, catches a design that serves a stale high word after the reset or lets the ignored strobe change the output.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;

   // What a given clock does with the read strobe
   typedef enum logic [1:0] {
      RD_NONE = 2'd0,
      RD_LOW  = 2'd1,
      RD_HIGH = 2'd2,
      RD_DROP = 2'd3
   } rd_kind_e;

endpackage

// File: rtl/sysctr_counter.sv
module sysctr_counter #(
   parameter int          CNT_W     = 64,
   parameter int          SEG_W     = 32,
   parameter logic [63:0] RESET_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   output logic [CNT_W-1:0] cnt_o
);
   localparam int NSEG = CNT_W / SEG_W;

   // carry into each segment; segment 0 always counts
   logic [NSEG:0] seg_cy;
   assign seg_cy[0] = 1'b1;

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      logic [SEG_W-1:0] seg_q;

      assign seg_cy[s+1] = seg_cy[s] & (&seg_q);
      assign cnt_o[s*SEG_W +: SEG_W] = seg_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            seg_q <= RESET_VAL[s*SEG_W +: SEG_W];
         end else if (seg_cy[s]) begin
            seg_q <= seg_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sysctr_window.sv
module sysctr_window
   import sysctr_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     rd_strobe_i,
   input  logic     core_rst_i,
   output logic     win_o,
   output rd_kind_e kind_o
);
   logic win_q;

   always_comb begin
      if (core_rst_i) begin
         kind_o = rd_strobe_i ? RD_DROP : RD_NONE;
      end else if (rd_strobe_i) begin
         kind_o = win_q ? RD_HIGH : RD_LOW;
      end else begin
         kind_o = RD_NONE;
      end
   end

   // only a low read opens the window; every other clock closes it
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         win_q <= 1'b0;
      end else begin
         win_q <= (kind_o == RD_LOW);
      end
   end

   assign win_o = win_q;

endmodule

// File: rtl/sysctr_readout.sv
module sysctr_readout
   import sysctr_pkg::*;
#(
   parameter int CNT_W = 64,
   parameter int SEG_W = 32,
   parameter int C_BIT = SEG_W - 1,
   parameter int Z_BIT = SEG_W - 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  rd_kind_e         kind_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [SEG_W-1:0] snap_o,
   output logic [SEG_W-1:0] data_o,
   output logic             flag_c_o,
   output logic             flag_z_o
);
   logic [SEG_W-1:0] snap_q;
   logic [SEG_W-1:0] data_q;
   logic             c_q;
   logic             z_q;
   logic [SEG_W-1:0] word_sel;
   logic             take;

   always_comb begin
      take = 1'b0;
      word_sel = data_q;
      unique case (kind_i)
         RD_LOW: begin
            take     = 1'b1;
            word_sel = cnt_i[SEG_W-1:0];
         end
         RD_HIGH: begin
            take     = 1'b1;
            word_sel = snap_q;
         end
         default: begin
            take     = 1'b0;
            word_sel = data_q;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         snap_q <= '0;
      end else if (kind_i == RD_LOW) begin
         snap_q <= cnt_i[CNT_W-1:SEG_W];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         data_q <= '0;
         c_q    <= 1'b0;
         z_q    <= 1'b0;
      end else if (take) begin
         data_q <= word_sel;
         c_q    <= word_sel[C_BIT];
         z_q    <= word_sel[Z_BIT];
      end
   end

   assign snap_o   = snap_q;
   assign data_o   = data_q;
   assign flag_c_o = c_q;
   assign flag_z_o = z_q;

endmodule

// File: rtl/sysctr_split_read.sv
module sysctr_split_read
   import sysctr_pkg::*;
#(
   parameter int          CNT_W     = 64,
   parameter int          WORD_W    = 32,
   parameter logic [63:0] CNT_RESET = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rd_strobe_i,
   input  logic              core_rst_i,
   output logic [WORD_W-1:0] rd_data_o,
   output logic              flag_c_o,
   output logic              flag_z_o,
   output logic              irq_hold_o
);
   localparam int C_BIT = WORD_W - 1;
   localparam int Z_BIT = WORD_W - 2;

   if (CNT_W != 2 * WORD_W) begin : g_bad_split
      $error("CNT_W must be exactly two words wide");
   end
   if (WORD_W < 2 || CNT_W > 64) begin : g_bad_width
      $error("WORD_W must be at least 2 and CNT_W at most 64");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] snap_w;
   logic              win_w;
   rd_kind_e          kind_w;

   sysctr_counter #(
      .CNT_W    (CNT_W),
      .SEG_W    (WORD_W),
      .RESET_VAL(CNT_RESET)
   ) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cnt_o (cnt_q)
   );

   sysctr_window u_win (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_strobe_i(rd_strobe_i),
      .core_rst_i (core_rst_i),
      .win_o      (win_w),
      .kind_o     (kind_w)
   );

   sysctr_readout #(
      .CNT_W(CNT_W),
      .SEG_W(WORD_W),
      .C_BIT(C_BIT),
      .Z_BIT(Z_BIT)
   ) u_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .kind_i  (kind_w),
      .cnt_i   (cnt_q),
      .snap_o  (snap_w),
      .data_o  (rd_data_o),
      .flag_c_o(flag_c_o),
      .flag_z_o(flag_z_o)
   );

   assign irq_hold_o = win_w;

endmodule

// File: rtl/sysctr_split_read_chk.sv
module sysctr_split_read_chk #(
   parameter int CNT_W  = 64,
   parameter int WORD_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              rd_strobe_i,
   input logic              core_rst_i,
   input logic [WORD_W-1:0] rd_data_o,
   input logic              flag_c_o,
   input logic              flag_z_o,
   input logic              irq_hold_o,
   input logic [CNT_W-1:0]  cnt_q
);
   // R1
   cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R2
   low_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_strobe_i && !core_rst_i && !irq_hold_o)
      |=> (rd_data_o == $past(cnt_q[WORD_W-1:0])) && irq_hold_o);

   // R3 R5
   high_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_strobe_i && !core_rst_i && irq_hold_o)
      |=> (rd_data_o == $past(cnt_q[CNT_W-1:WORD_W], 2)) && !irq_hold_o);

   // R4 R7
   one_cycle_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_hold_o |=> !irq_hold_o);

   // R8
   core_rst_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_rst_i |=> !irq_hold_o && $stable(rd_data_o));

   // R9
   flag_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_strobe_i && !core_rst_i)
      |=> (flag_c_o == rd_data_o[WORD_W-1]) && (flag_z_o == rd_data_o[WORD_W-2]));

   // R10
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_strobe_i |=> $stable(rd_data_o) && $stable(flag_c_o) && $stable(flag_z_o));

endmodule

bind sysctr_split_read sysctr_split_read_chk #(
   .CNT_W (CNT_W),
   .WORD_W(WORD_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .rd_strobe_i(rd_strobe_i),
   .core_rst_i (core_rst_i),
   .rd_data_o  (rd_data_o),
   .flag_c_o   (flag_c_o),
   .flag_z_o   (flag_z_o),
   .irq_hold_o (irq_hold_o),
   .cnt_q      (cnt_q)
);

// File: tb/sysctr_split_read_tb.sv
module sysctr_split_read_tb_top;
   localparam logic [63:0] START = 64'h0000_0001_FFFF_FFF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd = 1'b0;
   logic        crst = 1'b0;
   logic [31:0] rdata;
   logic        fc, fz, hold;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit cmp_en = 1'b0;

   always #2 clk = ~clk;

   sysctr_split_read #(
      .CNT_W    (64),
      .WORD_W   (32),
      .CNT_RESET(START)
   ) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .rd_strobe_i(rd),
      .core_rst_i (crst),
      .rd_data_o  (rdata),
      .flag_c_o   (fc),
      .flag_z_o   (fz),
      .irq_hold_o (hold)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference, updated at each rising edge
   logic [63:0] m_cnt;
   logic [31:0] m_snap;
   logic [31:0] m_data;
   bit          m_win;
   string       m_tag;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt  = START;
         m_snap = '0;
         m_data = '0;
         m_win  = 1'b0;
         m_tag  = "R1";
      end else begin
         if (crst) begin
            m_win = 1'b0;
            m_tag = "R8";
         end else if (rd && !m_win) begin
            m_data = m_cnt[31:0];
            m_snap = m_cnt[63:32];
            m_win  = 1'b1;
            m_tag  = "R2";
         end else if (rd) begin
            m_data = m_snap;
            m_win  = 1'b0;
            m_tag  = "R3";
         end else begin
            m_win = 1'b0;
            m_tag = "R10";
         end
         m_cnt = m_cnt + 64'd1;
      end
   end

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         chk(rdata == m_data, m_tag, {32'd0, rdata}, {32'd0, m_data});
         chk(hold == m_win, "R7", {63'd0, hold}, {63'd0, m_win});
         chk(fc == m_data[31] && fz == m_data[30], "R9",
             {62'd0, fc, fz}, {62'd0, m_data[31], m_data[30]});
      end
   end

   task automatic step(input bit r, input bit c);
      @(negedge clk);
      rd   = r;
      crst = c;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cmp_en = 1'b1;
      // reset state, R1
      chk(rdata == 32'd0 && !hold && !fc && !fz, "R1", {32'd0, rdata}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5: pair read whose low word is all ones
      while (m_cnt[31:0] != 32'hFFFF_FFFF) @(negedge clk);
      rd = 1'b1;
      @(negedge clk);
      chk(rdata == 32'hFFFF_FFFF, "R5", {32'd0, rdata}, 64'h0000_0000_FFFF_FFFF);
      @(negedge clk);
      chk(rdata == 32'h0000_0001, "R5", {32'd0, rdata}, 64'd1);
      rd = 1'b0;
      repeat (3) step(1'b0, 1'b0);

      // R6: burst of back-to-back reads alternates low/high
      for (int i = 0; i < 7; i++) begin
         step(1'b1, 1'b0);
         @(posedge clk);
         #1;
         chk(hold == ((i % 2) == 0), "R6", {63'd0, hold}, {63'd0, ((i % 2) == 0)});
      end
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);

      // R4: low read, idle clock, then the next read is low again
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      @(negedge clk);
      chk(rdata == m_cnt[31:0] - 32'd1 && hold, "R4",
          {32'd0, rdata}, {32'd0, m_cnt[31:0] - 32'd1});
      rd = 1'b0;
      step(1'b0, 1'b0);

      // R8: core reset with a strobe inside an open window
      step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      @(negedge clk);
      chk(rdata == m_data && !hold, "R8", {32'd0, rdata}, {32'd0, m_data});
      rd = 1'b1;
      crst = 1'b0;
      @(negedge clk);
      chk(rdata == m_cnt[31:0] - 32'd1, "R8", {32'd0, rdata}, {32'd0, m_cnt[31:0] - 32'd1});
      rd = 1'b0;
      step(1'b0, 1'b0);

      // R8: core reset alone mid-window
      step(1'b1, 1'b0);
      step(1'b0, 1'b1);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);

      // mixed pattern from a bench LFSR
      begin
         logic [15:0] lf = 16'hACE1;
         for (int k = 0; k < 400; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] | lf[3], (lf[7:4] == 4'hF));
         end
      end
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule